// File: doc/BRIEF.md
# Default Data-Access Protection Checker

This block sits on the data-memory path of a processor core that issues up to two data accesses per instruction, one from each data address port. While the page-descriptor protection lookup is switched off, it applies a fixed default rule: no data access from either port may reach the memory-mapped register region, whatever the privilege mode. Every request presented in a cycle is decoded against that region. The decode rejects the offending access, stops every access of the same instruction from completing, and raises a precise exception one clock later.

On a fault the block captures four values. The first is a cause code. The second is the exact byte address that was rejected. The third is a status word giving the direction, the port and the privilege mode. The fourth is the program counter of the faulting instruction, which the exception handler uses as its return address. The captured values stay in place until the next fault. The exception handler reads them through a small read port with a selector input.

When both ports of a bundle hit the region in the same cycle, the port-0 access is reported.

Top module: `dprot_checker`

## Requirements
- R1: After reset, `excpt_o` is 0 and `cause_o`, `fault_addr_o`, `fault_status_o` and `ret_addr_o` are all zero.
- R2: With `lookup_en_i` low, a valid access on either port faults when its address is at or above 0xFFC00000 (0xFFC00000 itself included), in user and in supervisor mode alike. An address of 0xFFBFFFFF or below never faults.
- R3: With `lookup_en_i` high, no access faults: `excpt_o` stays 0, every valid access passes, and the captured values do not change.
- R4: In a cycle in which any port faults, `acc_pass_o` is all zeros, including a valid non-faulting access on the other port. In any other cycle `acc_pass_o` equals `acc_valid_i`. The output is combinational in the same cycle.
- R5: `excpt_o` is high for exactly the one cycle that follows a faulting cycle. From the first fault onward, `cause_o` holds the protection-violation code 0x23.
- R6: `fault_addr_o` captures the full byte address of the reported access, unaligned addresses included.
- R7: `fault_status_o` is built from three bits and all its other bits are 0. Bit 16 is the direction (1 = write, 0 = read). Bit 17 is the port (1 = port 1, 0 = port 0). Bit 18 is the mode (1 = supervisor, 0 = user).
- R8: `ret_addr_o` captures `pc_i` from the faulting cycle.
- R9: When both ports fault in the same cycle, the address, direction and port of port 0 are captured.
- R10: `sw_rdata_o` is a combinational read of the captured values, zero-extended. The selector `sw_sel_i` picks the value: 0 gives the cause code, 1 the fault address, 2 the status word and 3 the return address.
- R11: In a cycle without a fault, the cause, address, status and return-address values keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lookup_en_i | input | 1 | Page-descriptor protection lookup enabled; the default rule is off while high |
| supv_i | input | 1 | Current privilege mode, 1 = supervisor |
| pc_i | input | PCW | Program counter of the instruction issuing this cycle |
| acc_valid_i | input | NSLOT | Per-port access request valid; bit 0 = port 0 |
| acc_write_i | input | NSLOT | Per-port direction, 1 = store |
| acc_addr_i | input | NSLOT*AW | Per-port byte address; port n at bits [n*AW +: AW] |
| acc_pass_o | output | NSLOT | Per-port permission to complete the access |
| excpt_o | output | 1 | One-cycle precise exception request |
| cause_o | output | 6 | Exception cause code |
| fault_addr_o | output | AW | Captured faulting byte address |
| fault_status_o | output | DW | Captured status word |
| ret_addr_o | output | PCW | Captured address of the faulting instruction |
| sw_sel_i | input | 2 | Software read selector |
| sw_rdata_o | output | DW | Software read data |

## Verification
The bench places accesses on both sides of the region boundary. A decode that is off by one, or that compares too few address bits, would then pass 0xFFC00000 or reject 0xFFBFFFFF. It drives bundles in which only one port hits the region, and a design that blocked only the faulting port would let the other port's access through. It drives bundles in which both ports fault, and a design with the wrong priority would report port 1's address and status. Further stimulus covers region accesses with the lookup enabled, unaligned addresses, and faults on back-to-back cycles. Under that stimulus, a design that captured the wrong values or lost a pulse would show a stale address or return address, or a merged exception.

// File: rtl/dprot_pkg.sv
`timescale 1ns/1ps
package dprot_pkg;
   localparam int CAUSE_W = 6;
   localparam logic [CAUSE_W-1:0] CAUSE_PROT_VIOL = 6'h23;

   // status word bit positions decoded by the exception handler
   localparam int ST_WRITE_BIT = 16;
   localparam int ST_PORT_BIT  = 17;
   localparam int ST_SUPV_BIT  = 18;

   typedef enum logic [1:0] {
      SW_CAUSE   = 2'd0,
      SW_ADDR    = 2'd1,
      SW_STATUS  = 2'd2,
      SW_RETADDR = 2'd3
   } sw_sel_e;
endpackage

// File: rtl/dprot_region_decode.sv
`timescale 1ns/1ps
module dprot_region_decode #(
   parameter int AW = 32,
   parameter logic [AW-1:0] BASE = AW'('hFFC0_0000)
) (
   input  logic [AW-1:0] addr_i,
   output logic          hit_o
);
   function automatic int low_set_bit(input logic [AW-1:0] v);
      int r;
      r = AW;
      for (int i = AW - 1; i >= 0; i--) begin
         if (v[i]) r = i;
      end
      return r;
   endfunction

   localparam int TZ = low_set_bit(BASE);
   localparam logic [AW-1:0] LOW_MASK = (TZ >= AW) ? '1 : ((AW'(1) << TZ) - AW'(1));
   localparam logic [AW-1:0] ONES_ABOVE = ~LOW_MASK;
   localparam bit IS_TOP = (BASE == ONES_ABOVE);

   if (BASE == '0) begin : g_bad_base
      $error("dprot_region_decode: BASE must be non-zero");
   end

   if (IS_TOP) begin : g_top_region
      // region runs to the top of the space: all upper bits set
      assign hit_o = &(addr_i | LOW_MASK);
   end else begin : g_cmp_region
      assign hit_o = (addr_i >= BASE);
   end
endmodule

// File: rtl/dprot_slot_check.sv
`timescale 1ns/1ps
module dprot_slot_check #(
   parameter int NSLOT = 2,
   parameter int AW    = 32,
   parameter logic [AW-1:0] BASE = AW'('hFFC0_0000)
) (
   input  logic               lookup_en_i,
   input  logic [NSLOT-1:0]   valid_i,
   input  logic [NSLOT*AW-1:0] addr_i,
   output logic [NSLOT-1:0]   fault_o
);
   logic [NSLOT-1:0] hit;

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      dprot_region_decode #(.AW(AW), .BASE(BASE)) u_dec (
         .addr_i (addr_i[s*AW +: AW]),
         .hit_o  (hit[s])
      );
      assign fault_o[s] = valid_i[s] & hit[s] & ~lookup_en_i;
   end
endmodule

// File: rtl/dprot_fault_select.sv
`timescale 1ns/1ps
module dprot_fault_select #(
   parameter int NSLOT = 2,
   parameter int AW    = 32
) (
   input  logic [NSLOT-1:0]    fault_i,
   input  logic [NSLOT-1:0]    write_i,
   input  logic [NSLOT*AW-1:0] addr_i,
   output logic                any_o,
   output logic [AW-1:0]       sel_addr_o,
   output logic                sel_write_o,
   output logic                sel_port_o
);
   logic [NSLOT-1:0] gnt;
   logic             taken;

   // lowest port number wins
   always_comb begin
      gnt   = '0;
      taken = 1'b0;
      for (int i = 0; i < NSLOT; i++) begin
         if (fault_i[i] && !taken) begin
            gnt[i] = 1'b1;
            taken  = 1'b1;
         end
      end
   end

   always_comb begin
      sel_addr_o  = '0;
      sel_write_o = 1'b0;
      sel_port_o  = 1'b0;
      for (int i = 0; i < NSLOT; i++) begin
         sel_addr_o  = sel_addr_o | (addr_i[i*AW +: AW] & {AW{gnt[i]}});
         sel_write_o = sel_write_o | (write_i[i] & gnt[i]);
         if (gnt[i]) sel_port_o = 1'(i);
      end
   end

   assign any_o = |fault_i;

   always_comb begin
      if (!$isunknown(fault_i)) begin
         AST_ONE_GRANT: assert ($onehot0(gnt) && ((|gnt) == (|fault_i))) // R9
            else $error("fault select granted zero or several ports");
      end
   end
endmodule

// File: rtl/dprot_capture.sv
`timescale 1ns/1ps
module dprot_capture import dprot_pkg::*; #(
   parameter int AW  = 32,
   parameter int PCW = 32,
   parameter int DW  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               take_i,
   input  logic [AW-1:0]      addr_i,
   input  logic               write_i,
   input  logic               port_i,
   input  logic               supv_i,
   input  logic [PCW-1:0]     pc_i,
   output logic               excpt_o,
   output logic [CAUSE_W-1:0] cause_o,
   output logic [AW-1:0]      addr_o,
   output logic [DW-1:0]      status_o,
   output logic [PCW-1:0]     ret_o
);
   logic [DW-1:0] st_next;

   always_comb begin
      st_next               = '0;
      st_next[ST_WRITE_BIT] = write_i;
      st_next[ST_PORT_BIT]  = port_i;
      st_next[ST_SUPV_BIT]  = supv_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         excpt_o  <= 1'b0;
         cause_o  <= '0;
         addr_o   <= '0;
         status_o <= '0;
         ret_o    <= '0;
      end else begin
         excpt_o <= take_i;
         if (take_i) begin
            cause_o  <= CAUSE_PROT_VIOL;
            addr_o   <= addr_i;
            status_o <= st_next;
            ret_o    <= pc_i;
         end
      end
   end

   AST_CAUSE_ON_EXC: assert property (@(posedge clk) disable iff (!rst_n)
      excpt_o |-> cause_o == CAUSE_PROT_VIOL) // R5
      else $error("exception without protection cause");

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !take_i |=> ($stable(addr_o) && $stable(status_o) && $stable(ret_o) && $stable(cause_o))) // R11
      else $error("captured values changed without a fault");

   AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      !take_i |=> !excpt_o) // R5
      else $error("exception raised without a faulting cycle");
endmodule

// File: rtl/dprot_checker.sv
`timescale 1ns/1ps
module dprot_checker import dprot_pkg::*; #(
   parameter int NSLOT = 2,
   parameter int AW    = 32,
   parameter int PCW   = 32,
   parameter int DW    = 32,
   parameter logic [AW-1:0] MMR_BASE = AW'('hFFC0_0000)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                lookup_en_i,
   input  logic                supv_i,
   input  logic [PCW-1:0]      pc_i,
   input  logic [NSLOT-1:0]    acc_valid_i,
   input  logic [NSLOT-1:0]    acc_write_i,
   input  logic [NSLOT*AW-1:0] acc_addr_i,
   output logic [NSLOT-1:0]    acc_pass_o,
   output logic                excpt_o,
   output logic [CAUSE_W-1:0]  cause_o,
   output logic [AW-1:0]       fault_addr_o,
   output logic [DW-1:0]       fault_status_o,
   output logic [PCW-1:0]      ret_addr_o,
   input  logic [1:0]          sw_sel_i,
   output logic [DW-1:0]       sw_rdata_o
);
   localparam logic [DW-1:0] ST_USED = (DW'(1) << ST_WRITE_BIT) | (DW'(1) << ST_PORT_BIT)
                                     | (DW'(1) << ST_SUPV_BIT);

   if (NSLOT < 1 || NSLOT > 2) begin : g_bad_nslot
      $error("dprot_checker: NSLOT must be 1 or 2");
   end
   if (AW > DW || PCW > DW) begin : g_bad_width
      $error("dprot_checker: AW and PCW must fit in DW");
   end
   if (DW <= ST_SUPV_BIT) begin : g_bad_dw
      $error("dprot_checker: DW too narrow for status word");
   end

   logic [NSLOT-1:0] fault;
   logic             any_fault;
   logic [AW-1:0]    sel_addr;
   logic             sel_write;
   logic             sel_port;

   dprot_slot_check #(.NSLOT(NSLOT), .AW(AW), .BASE(MMR_BASE)) u_slots (
      .lookup_en_i (lookup_en_i),
      .valid_i     (acc_valid_i),
      .addr_i      (acc_addr_i),
      .fault_o     (fault)
   );

   dprot_fault_select #(.NSLOT(NSLOT), .AW(AW)) u_sel (
      .fault_i     (fault),
      .write_i     (acc_write_i),
      .addr_i      (acc_addr_i),
      .any_o       (any_fault),
      .sel_addr_o  (sel_addr),
      .sel_write_o (sel_write),
      .sel_port_o  (sel_port)
   );

   dprot_capture #(.AW(AW), .PCW(PCW), .DW(DW)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .take_i   (any_fault),
      .addr_i   (sel_addr),
      .write_i  (sel_write),
      .port_i   (sel_port),
      .supv_i   (supv_i),
      .pc_i     (pc_i),
      .excpt_o  (excpt_o),
      .cause_o  (cause_o),
      .addr_o   (fault_addr_o),
      .status_o (fault_status_o),
      .ret_o    (ret_addr_o)
   );

   // precise: the whole instruction is dropped when any of its accesses faults
   assign acc_pass_o = acc_valid_i & {NSLOT{~any_fault}};

   always_comb begin
      unique case (sw_sel_e'(sw_sel_i))
         SW_CAUSE:   sw_rdata_o = DW'(cause_o);
         SW_ADDR:    sw_rdata_o = DW'(fault_addr_o);
         SW_STATUS:  sw_rdata_o = fault_status_o;
         SW_RETADDR: sw_rdata_o = DW'(ret_addr_o);
         default:    sw_rdata_o = '0;
      endcase
   end

   for (genvar s = 0; s < NSLOT; s++) begin : g_chk
      AST_REGION_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
         (!lookup_en_i && acc_valid_i[s] && acc_addr_i[s*AW +: AW] >= MMR_BASE)
            |-> acc_pass_o == '0) // R4
         else $error("region access allowed through");

      AST_EXC_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
         (!lookup_en_i && acc_valid_i[s] && acc_addr_i[s*AW +: AW] >= MMR_BASE)
            |=> (excpt_o && ret_addr_o == $past(pc_i))) // R8
         else $error("missing exception or wrong return address");
   end

   AST_PORT0_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (!lookup_en_i && acc_valid_i[0] && acc_addr_i[AW-1:0] >= MMR_BASE)
         |=> (!fault_status_o[ST_PORT_BIT] && fault_addr_o == $past(acc_addr_i[AW-1:0]))) // R9
      else $error("port 0 fault not reported first");

   AST_ENABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      lookup_en_i |=> !excpt_o) // R3
      else $error("fault raised while lookup enabled");

   AST_STATUS_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
      excpt_o |-> (fault_status_o & ~ST_USED) == '0) // R7
      else $error("reserved status bits set");
endmodule

// File: tb/dprot_checker_tb_top.sv
`timescale 1ns/1ps
module dprot_checker_tb_top;
   localparam int AW = 32;
   localparam logic [31:0] BASE = 32'hFFC0_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lookup_en_i = 1'b0;
   logic        supv_i = 1'b0;
   logic [31:0] pc_i = '0;
   logic [1:0]  acc_valid_i = '0;
   logic [1:0]  acc_write_i = '0;
   logic [63:0] acc_addr_i = '0;
   logic [1:0]  acc_pass_o;
   logic        excpt_o;
   logic [5:0]  cause_o;
   logic [31:0] fault_addr_o;
   logic [31:0] fault_status_o;
   logic [31:0] ret_addr_o;
   logic [1:0]  sw_sel_i = '0;
   logic [31:0] sw_rdata_o;

   always #2.5 clk = ~clk;

   dprot_checker dut_i (
      .clk(clk), .rst_n(rst_n), .lookup_en_i(lookup_en_i), .supv_i(supv_i), .pc_i(pc_i),
      .acc_valid_i(acc_valid_i), .acc_write_i(acc_write_i), .acc_addr_i(acc_addr_i),
      .acc_pass_o(acc_pass_o), .excpt_o(excpt_o), .cause_o(cause_o),
      .fault_addr_o(fault_addr_o), .fault_status_o(fault_status_o), .ret_addr_o(ret_addr_o),
      .sw_sel_i(sw_sel_i), .sw_rdata_o(sw_rdata_o)
   );

   typedef struct {
      bit          exc;
      logic [5:0]  cause;
      logic [31:0] addr;
      logic [31:0] status;
      logic [31:0] ret;
      string       tag;
   } exp_t;

   exp_t        sb_q[$];
   int          n_chk = 0;
   int          n_bad = 0;
   logic [5:0]  m_cause = '0;
   logic [31:0] m_addr = '0;
   logic [31:0] m_status = '0;
   logic [31:0] m_ret = '0;

   task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // driver: one instruction per call; pushes what the next cycle must show
   task automatic drive(input bit v0, input bit w0, input logic [31:0] a0,
                        input bit v1, input bit w1, input logic [31:0] a1,
                        input bit supv, input bit lk, input logic [31:0] pc, input string tag);
      bit   f0, f1, any;
      exp_t e;
      @(negedge clk);
      acc_valid_i = {v1, v0};
      acc_write_i = {w1, w0};
      acc_addr_i  = {a1, a0};
      supv_i      = supv;
      lookup_en_i = lk;
      pc_i        = pc;
      #0.5;
      f0  = v0 && (a0 >= BASE) && !lk;
      f1  = v1 && (a1 >= BASE) && !lk;
      any = f0 || f1;
      chk(tag, "pass", 64'(acc_pass_o), any ? 64'd0 : 64'({v1, v0}));
      if (any) begin
         m_cause  = 6'h23;
         m_addr   = f0 ? a0 : a1;
         m_status = ({31'd0, f0 ? w0 : w1} << 16) | ({31'd0, !f0} << 17) | ({31'd0, supv} << 18);
         m_ret    = pc;
      end
      e.exc = any; e.cause = m_cause; e.addr = m_addr; e.status = m_status; e.ret = m_ret; e.tag = tag;
      sb_q.push_back(e);
   endtask

   task automatic idle(input string tag);
      drive(0, 0, 32'h0, 0, 0, 32'h0, 0, 0, 32'h0, tag);
   endtask

   task automatic sw_read(input logic [1:0] sel, input logic [31:0] exp, input string tag);
      @(negedge clk);
      acc_valid_i = '0;
      sw_sel_i    = sel;
      #0.5;
      chk(tag, "sw_rdata", 64'(sw_rdata_o), 64'(exp));
   endtask

   // monitor: compares the registered outputs after each edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk(e.tag, "excpt", 64'(excpt_o), 64'(e.exc));
            chk(e.tag, "cause", 64'(cause_o), 64'(e.cause));
            chk(e.tag, "fault_addr", 64'(fault_addr_o), 64'(e.addr));
            chk(e.tag, "status", 64'(fault_status_o), 64'(e.status));
            chk(e.tag, "ret_addr", 64'(ret_addr_o), 64'(e.ret));
         end
      end
   end

   initial begin
      #(200000 * 5.0);
      n_bad++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "excpt", 64'(excpt_o), 64'd0);
      chk("R1", "cause", 64'(cause_o), 64'd0);
      chk("R1", "fault_addr", 64'(fault_addr_o), 64'd0);
      chk("R1", "status", 64'(fault_status_o), 64'd0);
      chk("R1", "ret_addr", 64'(ret_addr_o), 64'd0);
      rst_n = 1'b1;
      idle("R1_idle");

      // R2: just below the region, supervisor read on port 0
      drive(1, 0, 32'hFFBF_FFFF, 0, 0, 32'h0, 1, 0, 32'h0000_1000, "R2_below");
      // R2 / R7: boundary write from port 1 in supervisor mode
      drive(0, 0, 32'h0, 1, 1, 32'hFFC0_0000, 1, 0, 32'h0000_1010, "R2_R7_port1_write_supv");
      // R7: port 1 read in supervisor mode
      drive(0, 0, 32'h0, 1, 0, 32'hFFC0_0104, 1, 0, 32'h0000_1020, "R7_port1_read_supv");
      idle("R11_hold");
      // R4: bundle, port 0 user store faults, port 1 plain load must also be dropped
      drive(1, 1, 32'hFFC0_0100, 1, 0, 32'h0000_1000, 0, 0, 32'h0000_1030, "R4_bundle_drop");
      // R8: single-issue user load on port 0
      drive(1, 0, 32'hFFC0_0104, 0, 0, 32'h0, 0, 0, 32'h0000_1044, "R8_single_load");
      // R9: both ports fault, port 0 reported
      drive(1, 0, 32'hFFE0_0010, 1, 1, 32'hFFC0_0008, 1, 0, 32'h0000_1050, "R9_both_fault");
      // R3: region access with lookup enabled
      drive(1, 1, 32'hFFC0_2000, 1, 0, 32'hFFFF_0000, 0, 1, 32'h0000_1060, "R3_lookup_on");
      // R11: ordinary bundle, nothing captured
      drive(1, 1, 32'h0000_2000, 1, 0, 32'hFF80_0004, 0, 0, 32'h0000_1070, "R11_plain_bundle");
      // R6: unaligned top byte, user store on port 1
      drive(0, 0, 32'h0, 1, 1, 32'hFFFF_FFFF, 0, 0, 32'h0000_1080, "R6_unaligned");
      // R5: back-to-back faults, one pulse each, latest values win
      drive(1, 1, 32'hFFC0_0010, 0, 0, 32'h0, 1, 0, 32'h0000_1090, "R5_b2b_first");
      drive(1, 0, 32'hFFD0_0203, 0, 0, 32'h0, 0, 0, 32'h0000_1094, "R5_b2b_second");
      idle("R5_pulse_end");
      idle("R11_hold2");

      // R10: software read of the last capture
      sw_read(2'd0, 32'h0000_0023, "R10_cause");
      sw_read(2'd1, 32'hFFD0_0203, "R10_addr");
      sw_read(2'd2, 32'h0000_0000, "R10_status");
      sw_read(2'd3, 32'h0000_1094, "R10_ret");
      // R10: status after a supervisor port-1 store
      drive(0, 0, 32'h0, 1, 1, 32'hFFC1_0000, 1, 0, 32'h0000_10A0, "R7_port1_store_supv");
      idle("R11_hold3");
      sw_read(2'd2, 32'h0007_0000, "R10_status_full");

      repeat (3) @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule